// File: doc/BRIEF.md
# Stack-Relative Register File Controller

This block holds eight 80-bit floating-point values and reaches them through a rotating 3-bit top pointer, so that every operand is named as a distance from the current top of stack: ST(0) is the top, ST(7) the deepest entry. Loads push by moving the pointer down first and then writing. Popping forms move it up after their write. Because the pointer wraps, the same physical register is seen under a different stack index as the pointer moves.

A decoder in front of the block issues one command per clock. Supported commands are push, copy of the top into ST(i) with an optional pop, exchange of the top with ST(i), conditional copy of ST(i) into the top under a flag condition, explicit pointer step up or down, pointer clear, and arithmetic write-back. The arithmetic unit is outside. The block drives it two routed operands, chosen by the operand form and the reverse flag. It takes the result back into the destination the form selects, with an optional pop. The current pointer is visible in a 16-bit status word.

Top module: `stkrf_top`

## Requirements
- R1: While reset is high and after it is released, the pointer is 0, every entry reads 0 and status_word is all zero.
- R2: ST(i) always refers to physical entry (top + i) mod 8. With cmd_idx = i, form_to_i = 0 and reverse = 0, op_b shows ST(i) and op_a and top_data show ST(0).
- R3: Push (cmd_op = 1) decrements the pointer, wrapping from 0 to 7, and writes load_data into the new ST(0).
- R4: Store (cmd_op = 2) writes the old ST(0) into ST(cmd_idx), where index 0 leaves the contents alone. With cmd_pop = 1 it then increments the pointer, wrapping from 7 to 0. The write uses the mapping from before the pop.
- R5: Exchange (cmd_op = 3) swaps ST(0) and ST(cmd_idx) without moving the pointer. The operand-less form is issued with cmd_idx = 1.
- R6: Conditional move (cmd_op = 4) copies ST(cmd_idx) into ST(0) only when the condition selected by cond_sel holds, and never moves the pointer. The conditions are 0: ZF=1, 1: ZF=0, 2: CF=1, 3: CF=1 or ZF=1, 4: CF=0, 5: CF=0 and ZF=0, 6: PF=1, 7: PF=0.
- R7: Operand routing is combinational. With form_to_i = 0, op_a = ST(0) and op_b = ST(i). With form_to_i = 1, op_a = ST(i) and op_b = ST(0). reverse = 1 swaps op_a and op_b.
- R8: Arithmetic write-back (cmd_op = 8) writes arith_res into ST(0) when form_to_i = 0, or into ST(i) when form_to_i = 1, using the pre-pop mapping. With cmd_pop = 1 it then increments the pointer. With form_to_i = 1, i = 1 and pop, the result ends up as the new ST(0).
- R9: Pointer step up (cmd_op = 5) and step down (cmd_op = 6) change only the pointer, with wrap, and leave every physical entry unchanged.
- R10: Initialise (cmd_op = 7) sets the pointer to 0 and leaves the entries unchanged.
- R11: status_word carries the pointer in bits 13:11, and all other bits are 0.
- R12: No-op (cmd_op = 0), and any unlisted code, changes neither the pointer nor any entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 4 | Command code |
| cmd_idx | input | 3 | Stack-relative index i |
| cmd_pop | input | 1 | Pop after store or arithmetic write-back |
| form_to_i | input | 1 | Arithmetic form: 0 = result to ST(0), 1 = result to ST(i) |
| reverse | input | 1 | Swap the arithmetic operand order |
| cond_sel | input | 3 | Conditional-move condition select |
| flag_zf | input | 1 | Zero flag |
| flag_cf | input | 1 | Carry flag |
| flag_pf | input | 1 | Parity / unordered flag |
| load_data | input | 80 | Value pushed by a push |
| arith_res | input | 80 | Result from the external arithmetic unit |
| op_a | output | 80 | First routed operand |
| op_b | output | 80 | Second routed operand |
| top_data | output | 80 | Current ST(0), used for stores to memory |
| status_word | output | 16 | Status word with the pointer field |

## Verification
The hardest cases to reach are those where the pointer has wrapped, so that an index such as ST(6) lands on a low physical entry. Write-then-pop and exchange then have to resolve through the modulo add at the wrap point. The bench gets there by pushing more than eight values and by stepping the pointer down below zero. It then runs long random command mixes, so the pointer passes every position many times. After each command the bench sweeps all eight indices through op_b and compares the result with its own stack model.

// File: rtl/stkrf_pkg.sv
package stkrf_pkg;

    localparam int DATA_W   = 80;
    localparam int DEPTH    = 8;
    localparam int PTR_W    = $clog2(DEPTH);
    localparam int STATUS_W = 16;
    localparam int TOP_LSB  = 11;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [PTR_W-1:0]  ptr_t;

    typedef enum logic [3:0] {
        CMD_NOP   = 4'd0,
        CMD_PUSH  = 4'd1,
        CMD_STORE = 4'd2,
        CMD_XCHG  = 4'd3,
        CMD_CMOV  = 4'd4,
        CMD_INCP  = 4'd5,
        CMD_DECP  = 4'd6,
        CMD_INIT  = 4'd7,
        CMD_ARITH = 4'd8
    } cmd_e;

    typedef enum logic [2:0] {
        COND_EQ  = 3'd0,
        COND_NE  = 3'd1,
        COND_B   = 3'd2,
        COND_BE  = 3'd3,
        COND_NB  = 3'd4,
        COND_NBE = 3'd5,
        COND_U   = 3'd6,
        COND_NU  = 3'd7
    } cond_e;

    typedef enum logic [1:0] {
        PTR_HOLD,
        PTR_DEC,
        PTR_INC,
        PTR_CLR
    } ptr_op_e;

    typedef struct packed {
        logic  en;
        ptr_t  addr;
        word_t data;
    } wr_port_t;

    // Stack-relative index to physical slot: 3-bit wrap-around add.
    function automatic ptr_t rel2phys(ptr_t top, ptr_t idx);
        return ptr_t'(top + idx);
    endfunction

endpackage

// File: rtl/stkrf_ptr.sv
module stkrf_ptr
    import stkrf_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  ptr_op_e op,
    output ptr_t    top
);

    always_ff @(posedge clk) begin
        if (rst) begin
            top <= '0;
        end else begin
            case (op)
                PTR_DEC: top <= top - 1'b1;
                PTR_INC: top <= top + 1'b1;
                PTR_CLR: top <= '0;
                default: top <= top;
            endcase
        end
    end

endmodule

// File: rtl/stkrf_cond.sv
module stkrf_cond
    import stkrf_pkg::*;
(
    input  cond_e sel,
    input  logic  zf,
    input  logic  cf,
    input  logic  pf,
    output logic  take
);

    always_comb begin
        case (sel)
            COND_EQ:  take = zf;
            COND_NE:  take = ~zf;
            COND_B:   take = cf;
            COND_BE:  take = cf | zf;
            COND_NB:  take = ~cf;
            COND_NBE: take = ~cf & ~zf;
            COND_U:   take = pf;
            default:  take = ~pf;
        endcase
    end

endmodule

// File: rtl/stkrf_regs.sv
module stkrf_regs
    import stkrf_pkg::*;
#(
    parameter int NRD = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  wr_port_t wr0,
    input  wr_port_t wr1,
    input  ptr_t     rd_addr [NRD],
    output word_t    rd_data [NRD]
);

    word_t mem [DEPTH];

    // wr1 takes priority when both ports name the same slot.
    always_ff @(posedge clk) begin
        for (int e = 0; e < DEPTH; e++) begin
            if (rst) begin
                mem[e] <= '0;
            end else if (wr1.en && wr1.addr == PTR_W'(e)) begin
                mem[e] <= wr1.data;
            end else if (wr0.en && wr0.addr == PTR_W'(e)) begin
                mem[e] <= wr0.data;
            end
        end
    end

    for (genvar k = 0; k < NRD; k++) begin : g_rd
        assign rd_data[k] = mem[rd_addr[k]];
    end

endmodule

// File: rtl/stkrf_top.sv
module stkrf_top
    import stkrf_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [3:0]    cmd_op,
    input  logic [2:0]    cmd_idx,
    input  logic          cmd_pop,
    input  logic          form_to_i,
    input  logic          reverse,
    input  logic [2:0]    cond_sel,
    input  logic          flag_zf,
    input  logic          flag_cf,
    input  logic          flag_pf,
    input  logic [79:0]   load_data,
    input  logic [79:0]   arith_res,
    output logic [79:0]   op_a,
    output logic [79:0]   op_b,
    output logic [79:0]   top_data,
    output logic [15:0]   status_word
);

    cmd_e     cmd;
    ptr_t     top;
    ptr_t     phys_0;
    ptr_t     phys_i;
    ptr_op_e  ptr_op;
    logic     take;
    wr_port_t wr0;
    wr_port_t wr1;
    ptr_t     rd_addr [2];
    word_t    rd_data [2];
    word_t    st0;
    word_t    sti;
    word_t    raw_a;
    word_t    raw_b;

    assign cmd    = cmd_e'(cmd_op);
    assign phys_0 = top;
    assign phys_i = rel2phys(top, ptr_t'(cmd_idx));

    stkrf_ptr u_ptr (
        .clk (clk),
        .rst (rst),
        .op  (ptr_op),
        .top (top)
    );

    stkrf_cond u_cond (
        .sel  (cond_e'(cond_sel)),
        .zf   (flag_zf),
        .cf   (flag_cf),
        .pf   (flag_pf),
        .take (take)
    );

    assign rd_addr[0] = phys_0;
    assign rd_addr[1] = phys_i;

    stkrf_regs #(.NRD(2)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr0     (wr0),
        .wr1     (wr1),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    assign st0 = rd_data[0];
    assign sti = rd_data[1];

    // Operand routing for the external arithmetic unit.
    assign raw_a = form_to_i ? sti : st0;
    assign raw_b = form_to_i ? st0 : sti;
    assign op_a  = reverse ? raw_b : raw_a;
    assign op_b  = reverse ? raw_a : raw_b;

    assign top_data = st0;

    always_comb begin
        status_word = '0;
        status_word[TOP_LSB +: PTR_W] = top;
    end

    // Command decode: writes use the pre-update mapping, pointer moves same edge.
    always_comb begin
        wr0    = '0;
        wr1    = '0;
        ptr_op = PTR_HOLD;
        case (cmd)
            CMD_PUSH: begin
                wr0.en   = 1'b1;
                wr0.addr = top - 1'b1;
                wr0.data = load_data;
                ptr_op   = PTR_DEC;
            end
            CMD_STORE: begin
                wr0.en   = 1'b1;
                wr0.addr = phys_i;
                wr0.data = st0;
                ptr_op   = cmd_pop ? PTR_INC : PTR_HOLD;
            end
            CMD_XCHG: begin
                wr0.en   = 1'b1;
                wr0.addr = phys_0;
                wr0.data = sti;
                wr1.en   = 1'b1;
                wr1.addr = phys_i;
                wr1.data = st0;
            end
            CMD_CMOV: begin
                wr0.en   = take;
                wr0.addr = phys_0;
                wr0.data = sti;
            end
            CMD_INCP: ptr_op = PTR_INC;
            CMD_DECP: ptr_op = PTR_DEC;
            CMD_INIT: ptr_op = PTR_CLR;
            CMD_ARITH: begin
                wr0.en   = 1'b1;
                wr0.addr = form_to_i ? phys_i : phys_0;
                wr0.data = arith_res;
                ptr_op   = cmd_pop ? PTR_INC : PTR_HOLD;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/stkrf_chk.sv
module stkrf_chk (
    input logic        clk,
    input logic        rst,
    input logic [3:0]  cmd_op,
    input logic        cmd_pop,
    input logic [79:0] load_data,
    input logic [79:0] top_data,
    input logic [15:0] status_word
);

    logic [2:0] tp;
    assign tp = status_word[13:11];

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (status_word == 16'd0 && top_data == 80'd0));

    p_status_spare_r11: assert property (@(posedge clk) disable iff (rst)
        (status_word[15:14] == 2'd0 && status_word[10:0] == 11'd0));

    p_push_ptr_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_op == 4'd1 |=> tp == 3'($past(tp) - 3'd1));

    p_push_data_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_op == 4'd1 |=> top_data == $past(load_data));

    p_store_pop_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == 4'd2 && cmd_pop) |=> tp == 3'($past(tp) + 3'd1));

    p_xchg_ptr_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_op == 4'd3 |=> $stable(tp));

    p_cmov_ptr_r6: assert property (@(posedge clk) disable iff (rst)
        cmd_op == 4'd4 |=> $stable(tp));

    p_arith_pop_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_op == 4'd8 && cmd_pop) |=> tp == 3'($past(tp) + 3'd1));

    p_step_up_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_op == 4'd5 |=> tp == 3'($past(tp) + 3'd1));

    p_step_down_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_op == 4'd6 |=> tp == 3'($past(tp) - 3'd1));

    p_init_r10: assert property (@(posedge clk) disable iff (rst)
        cmd_op == 4'd7 |=> tp == 3'd0);

    p_nop_hold_r12: assert property (@(posedge clk) disable iff (rst)
        cmd_op == 4'd0 |=> ($stable(tp) && $stable(top_data)));

endmodule

bind stkrf_top stkrf_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .cmd_op      (cmd_op),
    .cmd_pop     (cmd_pop),
    .load_data   (load_data),
    .top_data    (top_data),
    .status_word (status_word)
);

// File: tb/stkrf_top_tb_top.sv
`timescale 1ns/1ps
module stkrf_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  cmd_op = '0;
    logic [2:0]  cmd_idx = '0;
    logic        cmd_pop = 1'b0;
    logic        form_to_i = 1'b0;
    logic        reverse = 1'b0;
    logic [2:0]  cond_sel = '0;
    logic        flag_zf = 1'b0;
    logic        flag_cf = 1'b0;
    logic        flag_pf = 1'b0;
    logic [79:0] load_data = '0;
    logic [79:0] arith_res = '0;
    logic [79:0] op_a;
    logic [79:0] op_b;
    logic [79:0] top_data;
    logic [15:0] status_word;

    int n_checks = 0;
    int n_errors = 0;
    int cycles = 0;

    logic [79:0] m_reg [8];
    logic [2:0]  m_top;

    always #5 clk = ~clk;

    stkrf_top dut_i (
        .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
        .cmd_pop(cmd_pop), .form_to_i(form_to_i), .reverse(reverse),
        .cond_sel(cond_sel), .flag_zf(flag_zf), .flag_cf(flag_cf),
        .flag_pf(flag_pf), .load_data(load_data), .arith_res(arith_res),
        .op_a(op_a), .op_b(op_b), .top_data(top_data), .status_word(status_word)
    );

    task automatic check80(input string req, input string what,
                           input logic [79:0] act, input logic [79:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [79:0] rnd80();
        logic [79:0] v;
        v = {$urandom(), $urandom(), 16'($urandom())};
        return v;
    endfunction

    function automatic logic [79:0] m_st(input int i);
        return m_reg[3'(m_top + 3'(i))];
    endfunction

    function automatic logic cond_ok(input logic [2:0] c, input logic zf,
                                     input logic cf, input logic pf);
        case (c)
            3'd0: return zf;
            3'd1: return !zf;
            3'd2: return cf;
            3'd3: return cf || zf;
            3'd4: return !cf;
            3'd5: return !cf && !zf;
            3'd6: return pf;
            default: return !pf;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd1: return "R3";
            4'd2: return "R4";
            4'd3: return "R5";
            4'd4: return "R6";
            4'd5, 4'd6: return "R9";
            4'd7: return "R10";
            4'd8: return "R8";
            default: return "R12";
        endcase
    endfunction

    // Observe the whole stack through the ports and compare with the model.
    task automatic sweep(input string req);
        @(negedge clk);
        cmd_op = 4'd0; form_to_i = 1'b0; reverse = 1'b0;
        check80("R11", "status", 80'(status_word), 80'({2'b00, m_top, 11'd0}));
        for (int i = 0; i < 8; i++) begin
            if (i > 0) @(negedge clk);
            cmd_idx = 3'(i);
            #2;
            check80(req, $sformatf("ST(%0d) via op_b", i), op_b, m_st(i));
            if (i == 0) begin
                check80("R2", "top_data", top_data, m_st(0));
                check80("R2", "op_a", op_a, m_st(0));
            end
        end
    endtask

    task automatic run_cmd(input logic [3:0] op, input logic [2:0] idx,
                           input logic pop, input logic fti, input logic rev,
                           input logic [2:0] cs, input logic zf, input logic cf,
                           input logic pf);
        logic [79:0] nreg [8];
        logic [2:0]  ntop;
        logic [2:0]  p0, pi;
        logic [79:0] ea, eb, ld, rs;
        ld = rnd80();
        rs = rnd80();
        @(negedge clk);
        cmd_op = op; cmd_idx = idx; cmd_pop = pop; form_to_i = fti;
        reverse = rev; cond_sel = cs; flag_zf = zf; flag_cf = cf;
        flag_pf = pf; load_data = ld; arith_res = rs;
        #1;
        ea = fti ? m_st(int'(idx)) : m_st(0);
        eb = fti ? m_st(0) : m_st(int'(idx));
        if (rev) begin
            check80("R7", "op_a routed", op_a, eb);
            check80("R7", "op_b routed", op_b, ea);
        end else begin
            check80("R7", "op_a routed", op_a, ea);
            check80("R7", "op_b routed", op_b, eb);
        end
        nreg = m_reg;
        ntop = m_top;
        p0 = m_top;
        pi = 3'(m_top + idx);
        case (op)
            4'd1: begin ntop = m_top - 3'd1; nreg[ntop] = ld; end
            4'd2: begin nreg[pi] = m_reg[p0]; if (pop) ntop = m_top + 3'd1; end
            4'd3: begin nreg[p0] = m_reg[pi]; nreg[pi] = m_reg[p0]; end
            4'd4: if (cond_ok(cs, zf, cf, pf)) nreg[p0] = m_reg[pi];
            4'd5: ntop = m_top + 3'd1;
            4'd6: ntop = m_top - 3'd1;
            4'd7: ntop = 3'd0;
            4'd8: begin
                nreg[fti ? pi : p0] = rs;
                if (pop) ntop = m_top + 3'd1;
            end
            default: ;
        endcase
        @(posedge clk);
        m_reg = nreg;
        m_top = ntop;
        sweep(tag_of(op));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                n_errors++;
                n_checks++;
                $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
                $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd5171));
        for (int i = 0; i < 8; i++) m_reg[i] = '0;
        m_top = 3'd0;
        repeat (3) @(negedge clk);
        #2;
        // R1: state held in reset
        check80("R1", "status in reset", 80'(status_word), 80'd0);
        check80("R1", "top_data in reset", top_data, 80'd0);
        @(negedge clk);
        rst = 1'b0;
        sweep("R1");

        // R3: ten pushes wrap the pointer past zero
        for (int k = 0; k < 10; k++) run_cmd(4'd1, 3'd0, 0, 0, 0, 0, 0, 0, 0);
        // R5: operand-less exchange, and deep exchange across the wrap
        run_cmd(4'd3, 3'd1, 0, 0, 0, 0, 0, 0, 0);
        run_cmd(4'd3, 3'd7, 0, 0, 0, 0, 0, 0, 0);
        // R6: every condition with flags both ways
        for (int c = 0; c < 8; c++) begin
            run_cmd(4'd4, 3'd2, 0, 0, 0, 3'(c), 1, 1, 1);
            run_cmd(4'd4, 3'd3, 0, 0, 0, 3'(c), 0, 0, 0);
            run_cmd(4'd4, 3'd5, 0, 0, 0, 3'(c), 1, 0, 0);
            run_cmd(4'd4, 3'd6, 0, 0, 0, 3'(c), 0, 1, 1);
        end
        // R8: operand-less popping form, then routing variants
        run_cmd(4'd8, 3'd1, 1, 1, 0, 0, 0, 0, 0);
        run_cmd(4'd8, 3'd4, 0, 1, 1, 0, 0, 0, 0);
        run_cmd(4'd8, 3'd3, 1, 0, 1, 0, 0, 0, 0);
        // R4: store to memory with pop, store to register with pop
        run_cmd(4'd2, 3'd0, 1, 0, 0, 0, 0, 0, 0);
        run_cmd(4'd2, 3'd5, 1, 0, 0, 0, 0, 0, 0);
        // R9 / R10: steps through the wrap, initialise keeps contents
        run_cmd(4'd7, 3'd0, 0, 0, 0, 0, 0, 0, 0);
        run_cmd(4'd6, 3'd0, 0, 0, 0, 0, 0, 0, 0);
        run_cmd(4'd5, 3'd0, 0, 0, 0, 0, 0, 0, 0);
        run_cmd(4'd5, 3'd0, 0, 0, 0, 0, 0, 0, 0);
        run_cmd(4'd7, 3'd0, 0, 0, 0, 0, 0, 0, 0);
        // R12: no-op and unlisted code
        run_cmd(4'd0, 3'd2, 1, 1, 1, 0, 1, 1, 1);
        run_cmd(4'd13, 3'd4, 1, 1, 0, 0, 1, 1, 1);

        // Random mix
        for (int n = 0; n < 400; n++) begin
            logic [3:0] op;
            op = 4'($urandom_range(0, 9));
            run_cmd(op, 3'($urandom()), 1'($urandom()), 1'($urandom()),
                    1'($urandom()), 3'($urandom()), 1'($urandom()),
                    1'($urandom()), 1'($urandom()));
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule